// File: doc/BRIEF.md
# Static Branch Direction Predictor with Resolve-Time Squash

This block sits beside the decode stage of a five-stage in-order pipeline. For each conditional branch the decoder presents, it makes a static taken/not-taken guess and the fetch address that follows from that guess. The guess comes from one of several fixed policies, picked by a mode input. A compiler hint bit can reverse the guess given by the displacement and opcode policies. The direction and the fall-through address of the branch are held in a one-entry prediction register until the branch comparator reports the real outcome.

When the real outcome differs from the held guess, the block raises a single-cycle mispredict pulse. The pipeline uses it to zero every control field of the wrong-path instruction, which turns that instruction into a bubble, and to load the fetch PC with the redirect address: the resolved target if the branch was taken, the branch PC plus 4 if it was not. If the decoder presents a branch in the same cycle as a squash, that branch is on the wrong path and is discarded. Two free-running counters tally the accepted branches and the mispredictions, so the accuracy of each policy can be measured.

Top module: `branch_predict_unit`

## Requirements
- R1: After reset, mispredict_o is low, no branch is pending, and both counters read zero.
- R2: In mode 2'b00 (fixed) and mode 2'b11 (reserved), the prediction is not taken whatever the hint bit and the displacement are, and pred_next_pc_o is the branch PC plus 4.
- R3: In mode 2'b01 (displacement), a negative displacement predicts taken and a zero or positive one predicts not taken. A hint bit of 1 inverts the result.
- R4: In mode 2'b10 (opcode), bit `opcode` of the map parameter (default 8'hA6, so opcodes 1, 2, 5 and 7 predict taken) gives the direction. A hint bit of 1 inverts it.
- R5: When the prediction is taken, pred_next_pc_o equals the branch PC + 4 + (sign-extended word displacement × 4). This holds for the most negative displacement too.
- R6: When a resolution arrives (res_valid_i high) while a branch is pending and res_taken_i differs from the held prediction, mispredict_o is high in that same cycle only. redirect_pc_o then equals res_target_i if the branch was taken, or the held branch PC + 4 if it was not.
- R7: A resolution that matches the held prediction gives no mispredict and clears the pending branch. A branch decoded in that same cycle is accepted.
- R8: A resolution that arrives while no branch is pending is ignored: mispredict_o stays low.
- R9: A branch strobe that arrives in the cycle of a mispredict is discarded. It is not counted and does not become pending.
- R10: branch_count_o increments once per accepted branch, and mispredict_count_o increments once per mispredict pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy select: 00 fixed not-taken, 01 displacement, 10 opcode, 11 reserved (not-taken) |
| br_valid_i | input | 1 | Decoder presents a conditional branch this cycle |
| br_opcode_i | input | OPC_W (3) | Branch opcode class |
| br_disp_i | input | DISP_W (16) | Signed word displacement |
| br_hint_i | input | 1 | Compiler hint, inverts the displacement/opcode guess |
| br_pc_i | input | PC_W (32) | PC of the branch |
| res_valid_i | input | 1 | Comparator has resolved the pending branch |
| res_taken_i | input | 1 | Resolved direction |
| res_target_i | input | PC_W (32) | Resolved branch target |
| pred_taken_o | output | 1 | Predicted direction for the decoded branch |
| pred_next_pc_o | output | PC_W (32) | Predicted next fetch address |
| mispredict_o | output | 1 | Squash-and-redirect pulse |
| redirect_pc_o | output | PC_W (32) | Correct-path fetch address, valid with mispredict_o |
| branch_count_o | output | CNT_W (16) | Accepted branch count |
| mispredict_count_o | output | CNT_W (16) | Mispredict count |

## Verification
The assertions assume that at most one branch is in flight. This means that a resolution refers to the last accepted branch, and res_target_i is that branch's true target. The stimulus decodes one branch, resolves it in a later cycle, and only then presents the next branch. The one exception is a directed case in which a new branch shares the resolving cycle, which is the pattern R7 and R9 describe. Inputs change only on the falling edge, so the combinational prediction and mispredict outputs are stable when they are sampled.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED_NT = 2'b00,
    MODE_DISP     = 2'b01,
    MODE_OPCODE   = 2'b10,
    MODE_RESERVED = 2'b11
  } bpu_mode_e;
endpackage

// File: rtl/bpu_policy.sv
module bpu_policy
  import bpu_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int DISP_W = 16,
  parameter logic [(1<<OPC_W)-1:0] OPC_MAP = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic              hint,
  output logic              taken
);
  logic base_dir;
  logic hint_ok;

  always_comb begin
    base_dir = 1'b0;
    hint_ok  = 1'b0;
    case (bpu_mode_e'(mode))
      MODE_DISP: begin
        base_dir = disp[DISP_W-1];
        hint_ok  = 1'b1;
      end
      MODE_OPCODE: begin
        base_dir = OPC_MAP[opcode];
        hint_ok  = 1'b1;
      end
      default: begin
        base_dir = 1'b0;
        hint_ok  = 1'b0;
      end
    endcase
    taken = base_dir ^ (hint & hint_ok);
  end

  // R2: fixed and reserved modes never predict taken
  p_fixed_nt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> !taken);

  // R3: a loop back-edge without hint is predicted taken
  p_backedge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !hint && disp[DISP_W-1]) |-> taken);
endmodule

// File: rtl/bpu_target.sv
module bpu_target #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 16
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [PC_W-1:0]   fall_pc,
  output logic [PC_W-1:0]   next_pc
);
  localparam int EXT_W = PC_W - DISP_W - 2;

  logic [PC_W-1:0] offset;
  logic [PC_W-1:0] tgt_pc;

  always_comb begin
    offset  = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    fall_pc = pc + PC_W'(4);
    tgt_pc  = fall_pc + offset;
    next_pc = taken ? tgt_pc : fall_pc;
  end
endmodule

// File: rtl/bpu_resolve.sv
module bpu_resolve #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic             pred_taken,
  input  logic [PC_W-1:0]  fall_pc,
  input  logic             res_valid,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  output logic             mispredict,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [CNT_W-1:0] br_cnt,
  output logic [CNT_W-1:0] mis_cnt
);
  logic             pend_vld_q, pend_vld_d;
  logic             pend_tkn_q, pend_tkn_d;
  logic [PC_W-1:0]  pend_pc_q;
  logic             accept;
  logic             pend_en;
  logic             br_cnt_en, mis_cnt_en;

  always_comb begin
    mispredict  = res_valid & pend_vld_q & (res_taken ^ pend_tkn_q);
    redirect_pc = res_taken ? res_target : pend_pc_q;
    accept      = br_valid & ~mispredict;
    pend_en     = accept | res_valid;
    pend_vld_d  = accept;
    pend_tkn_d  = accept & pred_taken;
    br_cnt_en   = accept;
    mis_cnt_en  = mispredict;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      pend_tkn_q <= 1'b0;
      pend_pc_q  <= '0;
    end else begin
      if (pend_en) begin
        pend_vld_q <= pend_vld_d;
        pend_tkn_q <= pend_tkn_d;
      end
      if (accept) begin
        pend_pc_q <= fall_pc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_cnt  <= '0;
      mis_cnt <= '0;
    end else begin
      if (br_cnt_en)  br_cnt  <= br_cnt + CNT_W'(1);
      if (mis_cnt_en) mis_cnt <= mis_cnt + CNT_W'(1);
    end
  end

  // R9: a squash leaves no branch pending
  p_squash_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> !pend_vld_q);

  // R9: a wrong-path branch strobe is not counted
  p_wrongpath_uncounted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict && br_valid) |=> br_cnt == $past(br_cnt));

  // R10: each mispredict pulse bumps the counter by one
  p_mis_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> mis_cnt == $past(mis_cnt) + CNT_W'(1));

  // R8: resolution with nothing pending never squashes
  p_orphan_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !pend_vld_q) |-> !mispredict);

  // R7: a matching resolution clears the pending branch unless a new one arrives
  p_match_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !mispredict && !br_valid) |=> !pend_vld_q);
endmodule

// File: rtl/branch_predict_unit.sv
module branch_predict_unit
  import bpu_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DISP_W = 16,
  parameter int OPC_W  = 3,
  parameter int CNT_W  = 16,
  parameter logic [(1<<OPC_W)-1:0] OPC_MAP = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              br_valid_i,
  input  logic [OPC_W-1:0]  br_opcode_i,
  input  logic [DISP_W-1:0] br_disp_i,
  input  logic              br_hint_i,
  input  logic [PC_W-1:0]   br_pc_i,
  input  logic              res_valid_i,
  input  logic              res_taken_i,
  input  logic [PC_W-1:0]   res_target_i,
  output logic              pred_taken_o,
  output logic [PC_W-1:0]   pred_next_pc_o,
  output logic              mispredict_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic [CNT_W-1:0]  branch_count_o,
  output logic [CNT_W-1:0]  mispredict_count_o
);
  logic            dir;
  logic [PC_W-1:0] fall_pc;

  bpu_policy #(
    .OPC_W(OPC_W), .DISP_W(DISP_W), .OPC_MAP(OPC_MAP)
  ) u_policy (
    .clk(clk), .rst_n(rst_n), .mode(mode_i), .opcode(br_opcode_i),
    .disp(br_disp_i), .hint(br_hint_i), .taken(dir)
  );

  bpu_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
    .pc(br_pc_i), .disp(br_disp_i), .taken(dir),
    .fall_pc(fall_pc), .next_pc(pred_next_pc_o)
  );

  bpu_resolve #(.PC_W(PC_W), .CNT_W(CNT_W)) u_resolve (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid_i), .pred_taken(dir),
    .fall_pc(fall_pc), .res_valid(res_valid_i), .res_taken(res_taken_i),
    .res_target(res_target_i), .mispredict(mispredict_o),
    .redirect_pc(redirect_pc_o), .br_cnt(branch_count_o),
    .mis_cnt(mispredict_count_o)
  );

  assign pred_taken_o = dir;

  // R6: the squash pulse never lasts two cycles without a fresh resolution
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict_o && !br_valid_i) |=> !mispredict_o);
endmodule

// File: tb/branch_predict_unit_tb.sv
module branch_predict_unit_tb;
  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  opc;
    logic [15:0] disp;
    logic        hint;
    logic [31:0] pc;
    logic        exp_t;
    logic        res_t;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 16'hFFFC, 1'b1, 32'h0000_1000, 1'b0, 1'b1},
    '{2'd0, 3'd7, 16'h0008, 1'b0, 32'h0000_1100, 1'b0, 1'b0},
    '{2'd1, 3'd0, 16'hFFFF, 1'b0, 32'h0000_2000, 1'b1, 1'b1},
    '{2'd1, 3'd0, 16'h0000, 1'b0, 32'h0000_2100, 1'b0, 1'b0},
    '{2'd1, 3'd0, 16'h0005, 1'b1, 32'h0000_2200, 1'b1, 1'b0},
    '{2'd1, 3'd0, 16'hFFF8, 1'b1, 32'h0000_2300, 1'b0, 1'b1},
    '{2'd2, 3'd1, 16'h0010, 1'b0, 32'h0000_3000, 1'b1, 1'b1},
    '{2'd2, 3'd0, 16'hFFF0, 1'b0, 32'h0000_3100, 1'b0, 1'b0},
    '{2'd2, 3'd3, 16'h0004, 1'b1, 32'h0000_3200, 1'b1, 1'b1},
    '{2'd2, 3'd7, 16'h0020, 1'b1, 32'h0000_3300, 1'b0, 1'b1},
    '{2'd3, 3'd5, 16'hFFFC, 1'b1, 32'h0000_4000, 1'b0, 1'b0},
    '{2'd3, 3'd7, 16'h0003, 1'b0, 32'h0000_4100, 1'b0, 1'b1},
    '{2'd1, 3'd0, 16'h8000, 1'b0, 32'h0004_0000, 1'b1, 1'b1}
  };

  logic        clk, rst_n;
  logic [1:0]  mode_i;
  logic        br_valid_i, br_hint_i;
  logic [2:0]  br_opcode_i;
  logic [15:0] br_disp_i;
  logic [31:0] br_pc_i;
  logic        res_valid_i, res_taken_i;
  logic [31:0] res_target_i;
  logic        pred_taken_o, mispredict_o;
  logic [31:0] pred_next_pc_o, redirect_pc_o;
  logic [15:0] branch_count_o, mispredict_count_o;

  int checks = 0, errors = 0, exp_br = 0, exp_mis = 0;
  bit done = 0;

  branch_predict_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .br_valid_i(br_valid_i),
    .br_opcode_i(br_opcode_i), .br_disp_i(br_disp_i), .br_hint_i(br_hint_i),
    .br_pc_i(br_pc_i), .res_valid_i(res_valid_i), .res_taken_i(res_taken_i),
    .res_target_i(res_target_i), .pred_taken_o(pred_taken_o),
    .pred_next_pc_o(pred_next_pc_o), .mispredict_o(mispredict_o),
    .redirect_pc_o(redirect_pc_o), .branch_count_o(branch_count_o),
    .mispredict_count_o(mispredict_count_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] tgt(logic [31:0] pc, logic [15:0] d);
    return pc + 32'd4 + {{14{d[15]}}, d, 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    br_valid_i = 0; res_valid_i = 0; res_taken_i = 0; res_target_i = '0;
  endtask

  task automatic decode(logic [1:0] m, logic [2:0] o, logic [15:0] d,
                        logic h, logic [31:0] pc);
    mode_i = m; br_opcode_i = o; br_disp_i = d; br_hint_i = h; br_pc_i = pc;
    br_valid_i = 1;
  endtask

  task automatic resolve(logic t, logic [31:0] target);
    res_valid_i = 1; res_taken_i = t; res_target_i = target;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [31:0] tg;
    rst_n = 0; mode_i = 0; br_opcode_i = 0; br_disp_i = 0; br_hint_i = 0;
    br_pc_i = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1 mispredict", 32'(mispredict_o), 0);
    chk("R1 branch_count", 32'(branch_count_o), 0);
    chk("R1 mispredict_count", 32'(mispredict_count_o), 0);
    resolve(1'b1, 32'h50);
    #1;
    chk("R1 nothing pending", 32'(mispredict_o), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      decode(VEC[i].mode, VEC[i].opc, VEC[i].disp, VEC[i].hint, VEC[i].pc);
      #1;
      tag = (VEC[i].mode == 2'd1) ? "R3" : (VEC[i].mode == 2'd2) ? "R4" : "R2";
      chk(tag, 32'(pred_taken_o), 32'(VEC[i].exp_t));
      tg = tgt(VEC[i].pc, VEC[i].disp);
      chk("R5 next pc", pred_next_pc_o, VEC[i].exp_t ? tg : VEC[i].pc + 32'd4);
      exp_br++;
      @(negedge clk);
      idle();
      resolve(VEC[i].res_t, tg);
      #1;
      if (VEC[i].res_t != VEC[i].exp_t) begin
        exp_mis++;
        chk("R6 mispredict", 32'(mispredict_o), 1);
        chk("R6 redirect", redirect_pc_o, VEC[i].res_t ? tg : VEC[i].pc + 32'd4);
      end else begin
        chk("R7 no mispredict", 32'(mispredict_o), 0);
      end
    end
    @(negedge clk);
    idle();
    #1;
    chk("R6 one-cycle pulse", 32'(mispredict_o), 0);
    chk("R10 branch_count", 32'(branch_count_o), 32'(exp_br));
    chk("R10 mispredict_count", 32'(mispredict_count_o), 32'(exp_mis));

    // R8: second resolution after the branch resolved is ignored
    resolve(1'b1, 32'h77);
    #1;
    chk("R8 orphan resolve", 32'(mispredict_o), 0);

    // R9: branch strobe during a squash is discarded
    @(negedge clk);
    idle();
    decode(2'd0, 3'd0, 16'h0004, 1'b0, 32'h0000_6000);
    exp_br++;
    @(negedge clk);
    idle();
    resolve(1'b1, 32'h0000_6014);
    decode(2'd1, 3'd0, 16'hFFFC, 1'b0, 32'h0000_7000);
    #1;
    exp_mis++;
    chk("R6 squash with strobe", 32'(mispredict_o), 1);
    chk("R6 squash redirect", redirect_pc_o, 32'h0000_6014);
    @(negedge clk);
    idle();
    resolve(1'b0, 32'h0);
    #1;
    chk("R9 dropped branch not pending", 32'(mispredict_o), 0);
    chk("R9 dropped branch not counted", 32'(branch_count_o), 32'(exp_br));

    // R7: matching resolve with a branch in the same cycle accepts it
    @(negedge clk);
    idle();
    decode(2'd1, 3'd0, 16'hFFFE, 1'b0, 32'h0000_8000);
    exp_br++;
    @(negedge clk);
    idle();
    resolve(1'b1, 32'h0000_7FFC);
    decode(2'd0, 3'd0, 16'h0002, 1'b0, 32'h0000_9000);
    #1;
    chk("R7 match no squash", 32'(mispredict_o), 0);
    exp_br++;
    @(negedge clk);
    idle();
    resolve(1'b1, 32'h0000_900C);
    #1;
    exp_mis++;
    chk("R7 new branch pending", 32'(mispredict_o), 1);
    chk("R7 redirect", redirect_pc_o, 32'h0000_900C);
    @(negedge clk);
    idle();
    #1;
    chk("R10 final branch_count", 32'(branch_count_o), 32'(exp_br));
    chk("R10 final mispredict_count", 32'(mispredict_count_o), 32'(exp_mis));

    // R1: reset in mid-run clears the counters
    rst_n = 0;
    #1;
    chk("R1 reset branch_count", 32'(branch_count_o), 0);
    chk("R1 reset mispredict_count", 32'(mispredict_count_o), 0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule